// File: doc/BRIEF.md
# Start-of-Transmission Entry Monitor for a D-PHY Data Lane

This block watches one data lane of a D-PHY link on a fast sampling clock. On each clock it takes the two sampled single-ended low-power levels of the lane and a flag that shows high-speed activity. It follows the low-power entry sequence into high-speed mode and times each step in samples. A well-formed entry leaves LP-11, passes through LP-01 and then LP-00, and only then shows high-speed activity.

For each session the monitor reports two lengths. The first is the low plateau: every sample spent in LP-01 or LP-00 between leaving LP-11 and the first high-speed sample. The second is the exit portion: the LP-01 samples alone. It raises a flicker-risk flag when the plateau is missing or shorter than the 50 ns minimum. It raises a separate warning when the exit portion is shorter than 50 ns. A low-power state out of order ends the measurement with a sequence error. The 50 ns limit becomes a sample count through the sample-period parameter, and software can replace that count at run time.

The monitor arms at reset and checks the first entry it sees. It holds the results and ignores the lane until a re-arm pulse announces the next pipeline start. A one-cycle done strobe marks the moment fresh results become valid.

Top module: `sot_monitor`

## Requirements
- R1: `sotOk` is 1 after a session whose order was LP-11, LP-01, LP-00, then a sample with `hsActive` high, and whose plateau length is at least the plateau threshold. Otherwise `sotOk` is 0. The lane state is `{lpP, lpN}`: 11 is LP-11, 01 is LP-01 (P low, N high), 00 is LP-00 and 10 is LP-10.
- R2: `lowLen` equals the number of samples in LP-01 or LP-00 that lie between the last LP-11 sample and the first sample with `hsActive` high.
- R3: `flickerRisk` is 1 when a session ends on high-speed activity with `lowLen` below the plateau threshold. This includes high-speed activity straight after LP-11, which reports `lowLen` = 0.
- R4: `exitLen` equals the number of LP-01 samples. `exitWarn` is 1 when a session ends on high-speed activity with `exitLen` below the exit threshold. It is independent of `sotOk` and `flickerRisk`.
- R5: Any of these conditions before high-speed activity ends the session with `seqErr`=1 and `sotOk`, `flickerRisk` and `exitWarn` all 0: LP-10; LP-00 straight after LP-11; a return to LP-11 after leaving it; LP-01 or LP-11 after LP-00. The lengths report the samples counted up to that point.
- R6: High-speed activity seen while still in LP-01 ends the session with `seqErr`=1 and `sotOk`=0. `flickerRisk` and `exitWarn` are still evaluated from the lengths.
- R7: `lowLen` and `exitLen` saturate at 2^CNT_W-1 and do not wrap.
- R8: `done` is high for exactly one cycle, in the cycle after the sample that ends the session. All results then hold, and lane activity has no effect, until a new session ends.
- R9: After reset the monitor is armed. It begins timing only after a sample of LP-11 with `hsActive` low. A `rearm` pulse while results are held starts a new session. A `rearm` pulse during a measurement is ignored.
- R10: With `thrOverride`=0 both thresholds equal ceil(50000 / SAMPLE_PS) samples. With `thrOverride`=1 the thresholds are `plateauMinCfg` and `exitMinCfg`.
- R11: Reset (`rstN` low) clears every output to 0 and abandons any session in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lpP | input | 1 | Sampled single-ended level of the positive wire |
| lpN | input | 1 | Sampled single-ended level of the negative wire |
| hsActive | input | 1 | High-speed activity present on the lane |
| rearm | input | 1 | Pulse marking a new pipeline start |
| thrOverride | input | 1 | Use the run-time thresholds instead of the derived one |
| plateauMinCfg | input | CNT_W | Run-time plateau threshold in samples |
| exitMinCfg | input | CNT_W | Run-time LP-01 threshold in samples |
| done | output | 1 | One-cycle strobe when results become valid |
| sotOk | output | 1 | Well-formed entry with an adequate plateau |
| flickerRisk | output | 1 | Plateau missing or too short |
| exitWarn | output | 1 | LP-01 portion too short |
| seqErr | output | 1 | Entry order broken |
| lowLen | output | CNT_W | Measured plateau in samples |
| exitLen | output | CNT_W | Measured LP-01 portion in samples |

## Verification
The bench builds the monitor with CNT_W = 5 and SAMPLE_PS = 8000. The derived threshold is then 7 samples, so plateaus of 6, 7 and 8 samples land on both sides of the limit with short stimulus. A 5-bit counter saturates at 31, so plateaus of 40 samples reach saturation well inside the run. The run-time override is also exercised, with thresholds of 2 and 3.

// File: rtl/sot_pkg.sv
package sot_pkg;

  typedef enum logic [2:0] {
    ST_WAIT11,
    ST_IN11,
    ST_IN01,
    ST_IN00,
    ST_HELD
  } sotState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrCnt;
    logic cntExit;
    logic cntLow;
    logic finish;
    logic viaZero;
    logic skipZero;
    logic abort;
  } ctrlStb_t;

  localparam logic [1:0] LP11 = 2'b11;
  localparam logic [1:0] LP01 = 2'b01;
  localparam logic [1:0] LP00 = 2'b00;

  function automatic int nsToSamples(input int ns, input int periodPs);
    return (ns * 1000 + periodPs - 1) / periodPs;
  endfunction

endpackage

// File: rtl/sot_ctrl.sv
module sot_ctrl
  import sot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] lpLvl,
  input  logic       hsActive,
  input  logic       rearm,
  output ctrlStb_t   stb
);

  sotState_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT11;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb = '0;
    unique case (state)
      ST_WAIT11: begin
        stb.clrCnt = 1'b1;
        if (lpLvl == LP11 && !hsActive) nextState = ST_IN11;
      end
      ST_IN11: begin
        if (hsActive) begin
          stb.finish = 1'b1;
          nextState = ST_HELD;
        end else if (lpLvl == LP01) begin
          stb.cntExit = 1'b1;
          stb.cntLow = 1'b1;
          nextState = ST_IN01;
        end else if (lpLvl != LP11) begin
          stb.abort = 1'b1;
          nextState = ST_HELD;
        end
      end
      ST_IN01: begin
        if (hsActive) begin
          stb.finish = 1'b1;
          stb.skipZero = 1'b1;
          nextState = ST_HELD;
        end else if (lpLvl == LP01) begin
          stb.cntExit = 1'b1;
          stb.cntLow = 1'b1;
        end else if (lpLvl == LP00) begin
          stb.cntLow = 1'b1;
          nextState = ST_IN00;
        end else begin
          stb.abort = 1'b1;
          nextState = ST_HELD;
        end
      end
      ST_IN00: begin
        if (hsActive) begin
          stb.finish = 1'b1;
          stb.viaZero = 1'b1;
          nextState = ST_HELD;
        end else if (lpLvl == LP00) begin
          stb.cntLow = 1'b1;
        end else begin
          stb.abort = 1'b1;
          nextState = ST_HELD;
        end
      end
      default: begin
        if (rearm) nextState = ST_WAIT11;
      end
    endcase
  end

  // R9
  wait_needs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT11 && hsActive) |=> (state == ST_WAIT11));

  // R5
  late_state_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IN00 && !hsActive && lpLvl != LP00) |-> stb.abort);

  // R8
  held_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HELD && !rearm) |=> (state == ST_HELD && !stb.finish && !stb.abort));

endmodule

// File: rtl/sot_datapath.sv
module sot_datapath
  import sot_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [CNT_W-1:0] plateauMin,
  input  logic [CNT_W-1:0] exitMin,
  output logic             done,
  output logic             sotOk,
  output logic             flickerRisk,
  output logic             exitWarn,
  output logic             seqErr,
  output logic [CNT_W-1:0] lowLen,
  output logic [CNT_W-1:0] exitLen
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lowCnt, exitCnt;
  logic lowShort, exitShort;

  assign lowShort  = lowCnt < plateauMin;
  assign exitShort = exitCnt < exitMin;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt  <= '0;
      exitCnt <= '0;
    end else if (stb.clrCnt) begin
      lowCnt  <= '0;
      exitCnt <= '0;
    end else begin
      if (stb.cntLow && lowCnt != CNT_MAX)   lowCnt  <= lowCnt + 1'b1;
      if (stb.cntExit && exitCnt != CNT_MAX) exitCnt <= exitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done <= 1'b0;
      sotOk <= 1'b0;
      flickerRisk <= 1'b0;
      exitWarn <= 1'b0;
      seqErr <= 1'b0;
      lowLen <= '0;
      exitLen <= '0;
    end else begin
      done <= stb.finish | stb.abort;
      if (stb.finish) begin
        lowLen <= lowCnt;
        exitLen <= exitCnt;
        flickerRisk <= lowShort;
        exitWarn <= exitShort;
        seqErr <= stb.skipZero;
        sotOk <= stb.viaZero && !lowShort;
      end else if (stb.abort) begin
        lowLen <= lowCnt;
        exitLen <= exitCnt;
        flickerRisk <= 1'b0;
        exitWarn <= 1'b0;
        seqErr <= 1'b1;
        sotOk <= 1'b0;
      end
    end
  end

  // R7
  low_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntLow && !stb.clrCnt && lowCnt == CNT_MAX) |=> (lowCnt == CNT_MAX));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  held_results_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(lowLen) && $stable(exitLen) && $stable(flickerRisk)));

  // R4
  exit_within_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (exitLen <= lowLen));

  // R1
  ok_needs_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && sotOk) |-> (lowLen >= $past(plateauMin) && !seqErr));

endmodule

// File: rtl/sot_monitor.sv
module sot_monitor
  import sot_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int SAMPLE_PS = 2000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lpP,
  input  logic             lpN,
  input  logic             hsActive,
  input  logic             rearm,
  input  logic             thrOverride,
  input  logic [CNT_W-1:0] plateauMinCfg,
  input  logic [CNT_W-1:0] exitMinCfg,
  output logic             done,
  output logic             sotOk,
  output logic             flickerRisk,
  output logic             exitWarn,
  output logic             seqErr,
  output logic [CNT_W-1:0] lowLen,
  output logic [CNT_W-1:0] exitLen
);

  localparam int LIMIT_NS = 50;
  localparam int DEF_SAMPLES = nsToSamples(LIMIT_NS, SAMPLE_PS);
  localparam logic [CNT_W-1:0] DEF_THR = DEF_SAMPLES[CNT_W-1:0];

  ctrlStb_t stb;
  logic [CNT_W-1:0] plateauMin, exitMin;

  assign plateauMin = thrOverride ? plateauMinCfg : DEF_THR;
  assign exitMin    = thrOverride ? exitMinCfg    : DEF_THR;

  sot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .lpLvl    ({lpP, lpN}),
    .hsActive (hsActive),
    .rearm    (rearm),
    .stb      (stb)
  );

  sot_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .plateauMin  (plateauMin),
    .exitMin     (exitMin),
    .done        (done),
    .sotOk       (sotOk),
    .flickerRisk (flickerRisk),
    .exitWarn    (exitWarn),
    .seqErr      (seqErr),
    .lowLen      (lowLen),
    .exitLen     (exitLen)
  );

endmodule

// File: tb/sot_monitor_tb.sv
module sot_monitor_tb;

  localparam int CW = 5;
  localparam int SPS = 8000;
  localparam int MAXC = (1 << CW) - 1;
  localparam int DEF = (50 * 1000 + SPS - 1) / SPS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lpP = 1'b1, lpN = 1'b1, hsActive = 1'b0, rearm = 1'b0, thrOverride = 1'b0;
  logic [CW-1:0] plateauMinCfg = '0, exitMinCfg = '0;
  logic done, sotOk, flickerRisk, exitWarn, seqErr;
  logic [CW-1:0] lowLen, exitLen;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int mPhase, mLow, mExit;
  int mDone, mOk, mFlick, mWarn, mSeq, mLowOut, mExitOut;

  always #4 clk = ~clk;

  sot_monitor #(.CNT_W(CW), .SAMPLE_PS(SPS)) u_dut (
    .clk(clk), .rstN(rstN), .lpP(lpP), .lpN(lpN), .hsActive(hsActive),
    .rearm(rearm), .thrOverride(thrOverride), .plateauMinCfg(plateauMinCfg),
    .exitMinCfg(exitMinCfg), .done(done), .sotOk(sotOk), .flickerRisk(flickerRisk),
    .exitWarn(exitWarn), .seqErr(seqErr), .lowLen(lowLen), .exitLen(exitLen)
  );

  function automatic int satInc(input int v);
    return (v < MAXC) ? v + 1 : MAXC;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase = 0; mLow = 0; mExit = 0;
      mDone = 0; mOk = 0; mFlick = 0; mWarn = 0; mSeq = 0; mLowOut = 0; mExitOut = 0;
    end else begin
      int lp, pThr, eThr, endKind;
      lp = {lpP, lpN};
      pThr = thrOverride ? int'(plateauMinCfg) : DEF;
      eThr = thrOverride ? int'(exitMinCfg) : DEF;
      endKind = 0; // 1 hs from 11, 2 hs from 01, 3 hs from 00, 4 bad order
      mDone = 0;
      case (mPhase)
        0: if (lp == 3 && !hsActive) begin mPhase = 1; mLow = 0; mExit = 0; end
        1: if (hsActive) endKind = 1;
           else if (lp == 1) begin mPhase = 2; mLow = 1; mExit = 1; end
           else if (lp != 3) endKind = 4;
        2: if (hsActive) endKind = 2;
           else if (lp == 1) begin mLow = satInc(mLow); mExit = satInc(mExit); end
           else if (lp == 0) begin mPhase = 3; mLow = satInc(mLow); end
           else endKind = 4;
        3: if (hsActive) endKind = 3;
           else if (lp == 0) mLow = satInc(mLow);
           else endKind = 4;
        default: if (rearm) mPhase = 0;
      endcase
      if (endKind != 0) begin
        mPhase = 4; mDone = 1; mLowOut = mLow; mExitOut = mExit;
        if (endKind == 4) begin
          mSeq = 1; mOk = 0; mFlick = 0; mWarn = 0;
        end else begin
          mFlick = (mLow < pThr); mWarn = (mExit < eThr);
          mSeq = (endKind == 2); mOk = (endKind == 3) && (mLow >= pThr);
        end
      end
    end
  end

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    cmp("R8", "done", done, mDone);
    cmp("R1", "sotOk", sotOk, mOk);
    cmp("R3", "flickerRisk", flickerRisk, mFlick);
    cmp("R4", "exitWarn", exitWarn, mWarn);
    cmp("R5", "seqErr", seqErr, mSeq);
    cmp("R2", "lowLen", lowLen, mLowOut);
    cmp("R4", "exitLen", exitLen, mExitOut);
  endtask

  task automatic step(input logic [1:0] lp, input logic hs, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareModel();
      lpP = lp[1]; lpN = lp[0]; hsActive = hs; rearm = 1'b0;
    end
  endtask

  task automatic pulseRearm();
    @(negedge clk); compareModel(); rearm = 1'b1;
    @(negedge clk); compareModel(); rearm = 1'b0;
  endtask

  task automatic expectSession(input string tag, input int eLow, input int eExit,
                               input int eOk, input int eFl, input int eWarn, input int eSeq);
    @(negedge clk);
    compareModel();
    cmp(tag, "done", done, 1);
    cmp(tag, "lowLen", lowLen, eLow);
    cmp(tag, "exitLen", exitLen, eExit);
    cmp(tag, "sotOk", sotOk, eOk);
    cmp(tag, "flickerRisk", flickerRisk, eFl);
    cmp(tag, "exitWarn", exitWarn, eWarn);
    cmp(tag, "seqErr", seqErr, eSeq);
  endtask

  task automatic expectZero(input string tag);
    cmp(tag, "done", done, 0);
    cmp(tag, "sotOk", sotOk, 0);
    cmp(tag, "flickerRisk", flickerRisk, 0);
    cmp(tag, "exitWarn", exitWarn, 0);
    cmp(tag, "seqErr", seqErr, 0);
    cmp(tag, "lowLen", lowLen, 0);
    cmp(tag, "exitLen", exitLen, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    expectZero("R11");
    rstN = 1'b1;

    // R1 R2 R4: well-formed entry, plateau 13, exit 8
    step(2'b11, 0, 3); step(2'b01, 0, 8); step(2'b00, 0, 5); step(2'b00, 1, 1);
    expectSession("R1", 13, 8, 1, 0, 0, 0);
    // R8: held, activity ignored
    step(2'b10, 0, 2); step(2'b11, 0, 2); step(2'b01, 0, 2);
    @(negedge clk); compareModel();
    cmp("R8", "done", done, 0); cmp("R8", "lowLen held", lowLen, 13);
    cmp("R8", "sotOk held", sotOk, 1);

    // R9: HS during wait must not start timing; then R3 absent plateau
    pulseRearm();
    step(2'b11, 1, 3); step(2'b01, 0, 2); step(2'b11, 0, 2); step(2'b11, 1, 1);
    expectSession("R3", 0, 0, 0, 1, 1, 0);

    // R3: plateau 6, one below threshold
    pulseRearm();
    step(2'b11, 0, 2); step(2'b01, 0, 2); step(2'b00, 0, 4); step(2'b00, 1, 1);
    expectSession("R3", 6, 2, 0, 1, 1, 0);

    // R4: plateau exactly 7 accepted, exit 3 warns separately
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 3); step(2'b00, 0, 4); step(2'b00, 1, 1);
    expectSession("R4", 7, 3, 1, 0, 1, 0);

    // R4: exit exactly 7 no warning
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 7); step(2'b00, 0, 2); step(2'b00, 1, 1);
    expectSession("R4", 9, 7, 1, 0, 0, 0);

    // R9 R5: rearm mid-measurement ignored, then return to LP-11 aborts
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 3); pulseRearm(); step(2'b11, 0, 1);
    expectSession("R5", 5, 5, 0, 0, 0, 1);

    // R5: LP-10 after LP-11
    pulseRearm();
    step(2'b11, 0, 2); step(2'b10, 0, 1);
    expectSession("R5", 0, 0, 0, 0, 0, 1);

    // R5: LP-00 straight after LP-11
    pulseRearm();
    step(2'b11, 0, 2); step(2'b00, 0, 1);
    expectSession("R5", 0, 0, 0, 0, 0, 1);

    // R5: LP-01 after LP-00
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 2); step(2'b00, 0, 2); step(2'b01, 0, 1);
    expectSession("R5", 4, 2, 0, 0, 0, 1);

    // R6: HS straight from LP-01
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 9); step(2'b01, 1, 1);
    expectSession("R6", 9, 9, 0, 0, 0, 1);

    // R7: plateau saturates
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 20); step(2'b00, 0, 20); step(2'b00, 1, 1);
    expectSession("R7", 31, 20, 1, 0, 0, 0);

    // R7: exit saturates too
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 40); step(2'b00, 0, 1); step(2'b00, 1, 1);
    expectSession("R7", 31, 31, 1, 0, 0, 0);

    // R10: run-time thresholds 3 and 2
    pulseRearm();
    thrOverride = 1'b1; plateauMinCfg = 5'd3; exitMinCfg = 5'd2;
    step(2'b11, 0, 1); step(2'b01, 0, 2); step(2'b00, 0, 1); step(2'b00, 1, 1);
    expectSession("R10", 3, 2, 1, 0, 0, 0);
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 1); step(2'b00, 0, 1); step(2'b00, 1, 1);
    expectSession("R10", 2, 1, 0, 1, 1, 0);
    thrOverride = 1'b0;

    // R11: reset mid-session, then armed again
    pulseRearm();
    step(2'b11, 0, 1); step(2'b01, 0, 3);
    @(negedge clk); compareModel(); rstN = 1'b0;
    @(negedge clk); compareModel(); expectZero("R11"); rstN = 1'b1;
    step(2'b11, 0, 1); step(2'b01, 0, 8); step(2'b00, 0, 1); step(2'b00, 1, 1);
    expectSession("R9", 9, 8, 1, 0, 0, 0);

    step(2'b11, 0, 3);
    finishRun();
  end

endmodule